// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This block adds or subtracts two 64-bit operands that carry a two-bit type tag in their least significant bits. A nonzero tag in either operand marks a non-integer value. The unit returns the 64-bit result and two groups of condition flags: one for the low 32-bit word and one for the full 64-bit word. In the 32-bit group, the overflow flag is also set when either tag is nonzero. This lets dynamically typed code check the type and the range of an addition with a single branch.

A per-operation option turns such an overflow into a trap request. When the trap fires, the result is not written and the flags are not updated, and the surrounding pipeline vectors to its handler. Operands are captured on a valid strobe, and all outputs are registered, so results appear exactly one cycle later. The unit accepts a new operation every cycle.

Top module: `tagalu_unit`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: An operation accepted with `in_valid` high shows `out_valid` high on the next cycle, with `result` equal to opa+opb when `op_sub`=0 or opa-opb when `op_sub`=1, modulo 2^64.
- R3: In a cycle with `in_valid` low, the next cycle shows `out_valid`, `wr_en`, `cc_we` and `tag_trap` low, and `result` holds its previous value.
- R4: The 32-bit overflow flag is set whenever bits 1:0 of either operand are nonzero.
- R5: The 32-bit overflow flag is also set on signed overflow of the low word: the sign bits (bit 31) of opa and of the effective second operand (opb for add, ~opb for subtract) agree, and bit 31 of the result differs from them.
- R6: The 64-bit overflow flag is set only by the same signed-overflow test on bit 63 and ignores the tags.
- R7: The carry flag is the carry out of bit 31 (32-bit group) or bit 63 (64-bit group) for add. For subtract it is a borrow: it is 1 when opa is unsigned-less than opb in that width.
- R8: The negative flag is bit 31 or bit 63 of the result, and the zero flag is set when bits 31:0 or bits 63:0 of the result are all zero.
- R9: Each flag group is a 4-bit vector with N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R10: With `op_trap`=1 and the 32-bit overflow flag set, the next cycle shows `tag_trap`=1 with `wr_en`=0 and `cc_we`=0.
- R11: With `op_trap`=0, or with no 32-bit overflow, a valid result shows `wr_en`=1, `cc_we`=1 and `tag_trap`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_trap | input | 1 | Request a trap on 32-bit overflow |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 64 | Sum or difference |
| icc | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc | output | 4 | 64-bit flags {N,Z,V,C} |
| wr_en | output | 1 | Destination write enable |
| cc_we | output | 1 | Flag update enable |
| tag_trap | output | 1 | Tag-overflow trap request |

## Verification
The tag check and the 32-bit signed-overflow test both drive the same V bit, and they can be true in the same cycle. The bench provokes this with 0x7FFFFFFF plus 1 with a tag bit set, both with and without the trap option. It judges the result by a single V bit, a single trap request and suppressed enables. The bench also issues back-to-back operations, where a trap is followed at once by a clean write. A scoreboard then confirms that the gating of one operation does not leak into the next.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/tagalu_tag_check.sv
module tagalu_tag_check #(
  parameter int W     = 64,
  parameter int TAG_W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         tag_bad
);
  always_comb tag_bad = |(a[TAG_W-1:0] | b[TAG_W-1:0]);
endmodule

// File: rtl/tagalu_addsub.sv
module tagalu_addsub #(
  parameter int W    = 64,
  parameter int LO_W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] b_eff,
  output logic [W-1:0] sum,
  output logic         carry_lo,
  output logic         carry_hi
);
  localparam int HI_W = W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  // subtract as a + ~b + 1, split at the word boundary to expose the middle carry
  always_comb begin
    b_eff    = sub ? ~b : b;
    lo_sum   = {1'b0, a[LO_W-1:0]} + {1'b0, b_eff[LO_W-1:0]} + {{LO_W{1'b0}}, sub};
    carry_lo = lo_sum[LO_W];
    hi_sum   = {1'b0, a[W-1:LO_W]} + {1'b0, b_eff[W-1:LO_W]} + {{HI_W{1'b0}}, carry_lo};
    carry_hi = hi_sum[HI_W];
    sum      = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  end
endmodule

// File: rtl/tagalu_flags.sv
module tagalu_flags
  import tagalu_pkg::*;
#(
  parameter int W    = 64,
  parameter int LO_W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  input  logic [W-1:0] sum,
  input  logic         carry_lo,
  input  logic         carry_hi,
  input  logic         sub,
  input  logic         tag_bad,
  output cc_t          icc,
  output cc_t          xcc
);
  logic sovf_lo;
  logic sovf_hi;

  always_comb begin
    sovf_lo = (a[LO_W-1] == b_eff[LO_W-1]) && (sum[LO_W-1] != a[LO_W-1]);
    sovf_hi = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    icc.n   = sum[LO_W-1];
    icc.z   = ~|sum[LO_W-1:0];
    icc.v   = sovf_lo | tag_bad;
    icc.c   = carry_lo ^ sub;
    xcc.n   = sum[W-1];
    xcc.z   = ~|sum;
    xcc.v   = sovf_hi;
    xcc.c   = carry_hi ^ sub;
  end
endmodule

// File: rtl/tagalu_unit.sv
module tagalu_unit
  import tagalu_pkg::*;
#(
  parameter int W     = 64,
  parameter int LO_W  = 32,
  parameter int TAG_W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         op_sub,
  input  logic         op_trap,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [3:0]   icc,
  output logic [3:0]   xcc,
  output logic         wr_en,
  output logic         cc_we,
  output logic         tag_trap
);
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         carry_lo;
  logic         carry_hi;
  logic         tag_bad;
  cc_t          icc_c;
  cc_t          xcc_c;

  tagalu_tag_check #(.W(W), .TAG_W(TAG_W)) u_tag (
    .a(opa), .b(opb), .tag_bad(tag_bad)
  );

  tagalu_addsub #(.W(W), .LO_W(LO_W)) u_add (
    .a(opa), .b(opb), .sub(op_sub), .b_eff(b_eff), .sum(sum),
    .carry_lo(carry_lo), .carry_hi(carry_hi)
  );

  tagalu_flags #(.W(W), .LO_W(LO_W)) u_flg (
    .a(opa), .b_eff(b_eff), .sum(sum), .carry_lo(carry_lo),
    .carry_hi(carry_hi), .sub(op_sub), .tag_bad(tag_bad),
    .icc(icc_c), .xcc(xcc_c)
  );

  // next-state
  logic         vld_n, trap_n, wr_n;
  logic [W-1:0] res_n;
  logic [3:0]   icc_n, xcc_n;

  always_comb begin
    vld_n  = in_valid;
    trap_n = in_valid & op_trap & icc_c.v;
    wr_n   = in_valid & ~trap_n;
    res_n  = in_valid ? sum   : result;
    icc_n  = in_valid ? icc_c : icc;
    xcc_n  = in_valid ? xcc_c : xcc;
  end

  // control registers: every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      cc_we     <= 1'b0;
      tag_trap  <= 1'b0;
    end else begin
      out_valid <= vld_n;
      wr_en     <= wr_n;
      cc_we     <= wr_n;
      tag_trap  <= trap_n;
    end
  end

  // data registers: enabled by the operation strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      icc    <= '0;
      xcc    <= '0;
    end else if (in_valid) begin
      result <= res_n;
      icc    <= icc_n;
      xcc    <= xcc_n;
    end
  end
endmodule

// File: rtl/tagalu_unit_chk.sv
module tagalu_unit_chk #(
  parameter int W     = 64,
  parameter int TAG_W = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         op_trap,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic [3:0]   icc,
  input logic [3:0]   xcc,
  input logic         wr_en,
  input logic         cc_we,
  input logic         tag_trap
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tag_trap |-> (!wr_en && !cc_we)); // R10

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wr_en ^ tag_trap)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_en && !cc_we && !tag_trap)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(in_valid)) |-> $stable(result)); // R3

  AST_TAG_SETS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid) && $past(|(opa[TAG_W-1:0] | opb[TAG_W-1:0]))) |-> icc[1]); // R4

  AST_TRAP_NEEDS_OPT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && tag_trap) |-> ($past(op_trap) && icc[1])); // R10

  AST_ZERO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && xcc[2]) |-> icc[2]); // R8

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid))); // R2
endmodule

bind tagalu_unit tagalu_unit_chk #(.W(W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_trap(op_trap),
  .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
  .icc(icc), .xcc(xcc), .wr_en(wr_en), .cc_we(cc_we), .tag_trap(tag_trap)
);

// File: tb/tb_tagalu_unit.sv
module tb_tagalu_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, op_sub, op_trap;
  logic [63:0] opa, opb;
  logic        out_valid, wr_en, cc_we, tag_trap;
  logic [63:0] result;
  logic [3:0]  icc, xcc;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    logic [63:0] res;
    logic [3:0]  icc;
    logic [3:0]  xcc;
    logic        wr;
    logic        cc;
    logic        trap;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  tagalu_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .op_trap(op_trap), .opa(opa), .opb(opb), .out_valid(out_valid),
    .result(result), .icc(icc), .xcc(xcc), .wr_en(wr_en), .cc_we(cc_we),
    .tag_trap(tag_trap)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one operation per call, expected item computed from the requirements
  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input bit sub, input bit trap, input string req);
    exp_t e;
    logic [64:0] w;
    logic [32:0] l;
    logic        bs31, bs63, tag;
    @(negedge clk);
    in_valid = 1'b1; op_sub = sub; op_trap = trap; opa = a; opb = b;
    e.res = sub ? a - b : a + b;
    if (sub) begin
      e.icc[0] = a[31:0] < b[31:0];
      e.xcc[0] = a < b;
      bs31 = ~b[31]; bs63 = ~b[63];
    end else begin
      l = {1'b0, a[31:0]} + {1'b0, b[31:0]};
      w = {1'b0, a} + {1'b0, b};
      e.icc[0] = l[32];
      e.xcc[0] = w[64];
      bs31 = b[31]; bs63 = b[63];
    end
    tag = (a[1:0] != 2'b00) || (b[1:0] != 2'b00);
    e.icc[3] = e.res[31];
    e.icc[2] = (e.res[31:0] == 32'd0);
    e.icc[1] = tag || ((a[31] == bs31) && (e.res[31] != a[31]));
    e.xcc[3] = e.res[63];
    e.xcc[2] = (e.res == 64'd0);
    e.xcc[1] = (a[63] == bs63) && (e.res[63] != a[63]);
    e.trap   = trap && e.icc[1];
    e.wr     = !e.trap;
    e.cc     = !e.trap;
    e.req    = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = 64'hDEAD_BEEF_0000_0003;
      opb = 64'h1;
    end
  endtask

  // monitor: pop and compare whenever a result is presented
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid", 160'd1, 160'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({result, icc, xcc, wr_en, cc_we, tag_trap} ==
                {e.res, e.icc, e.xcc, e.wr, e.cc, e.trap}, e.req,
                "{result,icc,xcc,wr,cc,trap}",
                {85'd0, result, icc, xcc, wr_en, cc_we, tag_trap},
                {85'd0, e.res, e.icc, e.xcc, e.wr, e.cc, e.trap});
        end
      end
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; op_trap = 1'b0;
    opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: all outputs low during reset
    check({out_valid, result, icc, xcc, wr_en, cc_we, tag_trap} == '0, "R1",
          "outputs in reset", {86'd0, out_valid, result, icc, xcc, wr_en, cc_we, tag_trap}, 160'd0);
    rst_n = 1'b1;
    idle(2);

    drive(64'd4, 64'd8, 0, 0, "R2 add");
    drive(64'd8, 64'd12, 1, 0, "R7 R8 sub borrow negative");
    drive(64'h0000_0000_7FFF_FFFC, 64'd4, 0, 0, "R5 low-word signed overflow");
    drive(64'd1, 64'd4, 0, 0, "R4 tag in opa, R6 no 64-bit V");
    drive(64'd8, 64'd6, 0, 0, "R4 tag in opb");
    drive(64'd9, 64'd4, 0, 1, "R10 trap on tag");
    drive(64'd16, 64'd4, 0, 1, "R11 trap option clean");
    drive(64'h8000_0000_0000_0000, 64'd4, 1, 0, "R6 64-bit overflow on sub");
    drive(64'hFFFF_FFFF_FFFF_FFFC, 64'd4, 0, 0, "R7 R8 R9 carry and zero both");
    drive(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1, 0, "R8 sub equal zero no borrow");
    drive(64'h0000_0000_7FFF_FFFC, 64'd4, 0, 1, "R10 trap on arithmetic overflow");
    drive(64'h0000_0000_7FFF_FFFF, 64'd1, 0, 1, "R10 tag and overflow together");
    drive(64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, "R11 tag and overflow no trap");
    drive(64'h7FFF_FFFF_FFFF_FFFC, 64'd4, 0, 0, "R6 R9 64-bit add overflow");
    drive(64'h0000_0001_0000_0000, 64'd4, 1, 0, "R7 low-word borrow only");
    idle(1);
    held = 64'h0000_0000_FFFF_FFFC;
    idle(2);
    #1;
    // R3: idle cycles quiet and result held
    check(!out_valid && !wr_en && !cc_we && !tag_trap, "R3", "idle controls",
          {156'd0, out_valid, wr_en, cc_we, tag_trap}, 160'd0);
    check(result == held, "R3", "idle result hold", {96'd0, result}, {96'd0, held});
    check(exp_q.size() == 0, "R2", "scoreboard drained", 160'(exp_q.size()), 160'd0);
    done = 1;
    summary();
  end
endmodule